// File: doc/BRIEF.md
# Start-Framed Serial-to-Vector Deserializer

This block collects a fast stream of scalar samples into a wide vector of `RATIO` elements. The vector is presented at a slow rate. A free-running phase counter divides the input clock into slow periods of `RATIO + IDLE_CYCLES` cycles. The first `RATIO` cycles of each period are gathering slots. The remaining cycles are idle slots, and samples offered in them are ignored. The counter raises `slow_strobe` on the last cycle of every period. The output registers change only on that cycle.

A frame opens only on a cycle that is a gathering slot and where `valid_in` and `start_in` are both high. It collects `RATIO` accepted samples in arrival order and may run across a period boundary. A new qualified start before the frame is full throws the partial frame away and opens a fresh frame at that sample. A completed vector is presented at the end of the period in which it completed, so it is visible from the following period. In a period with no completed frame, the previous vector is held and `valid_out` is low. Until the first frame completes, the output shows the `INIT_VEC` parameter.

Top module: `serial_frame_gatherer`

## Requirements
- R1: `slow_strobe` is high for exactly one cycle in every `RATIO + IDLE_CYCLES` cycles. The first strobe comes on the `RATIO + IDLE_CYCLES`-th clock edge after reset is released.
- R2: Element i of `vec_out` (bits `i*WIDTH +: WIDTH`) is the i-th accepted sample of the frame. Element 0 is the sample that carried the start.
- R3: `vec_out` and `valid_out` change only on the clock edge where `slow_strobe` is high. A frame that completes during a period is presented on that period's strobe edge.
- R4: A sample with `start_in` high and `valid_in` low is dropped. A sample with `valid_in` high and `start_in` low is also dropped when no frame is open.
- R5: A sample with `valid_in` and `start_in` both high that arrives in a gathering slot discards any partial frame. That sample becomes element 0 of a new frame.
- R6: When no frame completed during a period, the strobe edge of that period holds `vec_out` unchanged and drives `valid_out` low.
- R7: Reset loads `INIT_VEC` into `vec_out`, clears `valid_out` and the phase counter, and closes any open frame. `vec_out` keeps `INIT_VEC` until the first frame completes.
- R8: Samples offered while the phase is `RATIO` or higher (the idle slots) are neither gathered nor able to start a frame.
- R9: After a frame collects `RATIO` samples it closes. Later valid samples without `start_in` are dropped until the next qualified start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | WIDTH | Scalar input sample |
| valid_in | input | 1 | Sample qualifier |
| start_in | input | 1 | Frame-start marker |
| vec_out | output | RATIO*WIDTH | Gathered vector, element 0 in the low bits |
| valid_out | output | 1 | High for a period whose vector was newly completed |
| slow_strobe | output | 1 | Pulse on the last cycle of each slow period |

## Verification
The embedded assertions check the following on every cycle:
- the counter wraps after each strobe;
- the outputs stay stable between strobes;
- an idle slot never touches the frame state;
- a period without a completion holds the vector and drops `valid_out`.

Other behaviours depend on sample order and data values and can be shown only by the bench's scenarios:
- correct element placement;
- discarding a partial frame on an early restart;
- dropping unqualified and extra samples;
- frames that straddle an idle slot.

A behavioural queue model checks these on every clock under both directed and random stimulus.

// File: rtl/serial_frame_gatherer.sv
module serial_frame_gatherer #(
  parameter int WIDTH = 8,
  parameter int RATIO = 3,
  parameter int IDLE_CYCLES = 1,
  parameter logic [RATIO*WIDTH-1:0] INIT_VEC = '0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [WIDTH-1:0]       din,
  input  logic                   valid_in,
  input  logic                   start_in,
  output logic [RATIO*WIDTH-1:0] vec_out,
  output logic                   valid_out,
  output logic                   slow_strobe
);
  localparam int PERIOD = RATIO + IDLE_CYCLES;
  localparam int CW = $clog2(PERIOD + 1);
  localparam int IW = $clog2(RATIO + 1);

  logic [CW-1:0]          cnt;
  logic [IW-1:0]          idx, wr_idx;
  logic                   open_q, pend_q;
  logic [RATIO*WIDTH-1:0] acc, pend_vec, fill;
  logic                   gather, restart, extend, done;

  assign slow_strobe = (cnt == CW'(PERIOD - 1));
  assign gather  = (cnt < CW'(RATIO)) && valid_in;
  assign restart = gather && start_in;
  assign extend  = gather && !start_in && open_q;
  assign wr_idx  = restart ? '0 : idx;
  assign done    = (restart || extend) && (wr_idx == IW'(RATIO - 1));

  always_comb begin
    fill = acc;
    for (int i = 0; i < RATIO; i++)
      if (wr_idx == IW'(i)) fill[i*WIDTH +: WIDTH] = din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      idx       <= '0;
      open_q    <= 1'b0;
      pend_q    <= 1'b0;
      acc       <= '0;
      pend_vec  <= '0;
      vec_out   <= INIT_VEC;
      valid_out <= 1'b0;
    end else begin
      cnt <= slow_strobe ? '0 : cnt + 1'b1;
      if (restart || extend) begin
        acc    <= fill;
        idx    <= wr_idx + 1'b1;
        open_q <= !done;
      end
      if (slow_strobe) begin
        valid_out <= done || pend_q;
        if (done) vec_out <= fill;
        else if (pend_q) vec_out <= pend_vec;
        pend_q <= 1'b0;
      end else if (done) begin
        pend_q   <= 1'b1;
        pend_vec <= fill;
      end
    end
  end

  AST_STROBE_WRAP: assert property (@(posedge clk) disable iff (rst)
    slow_strobe |=> cnt == '0); // R1
  AST_OUT_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
    !slow_strobe |=> $stable(vec_out) && $stable(valid_out)); // R3
  AST_HOLD_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
    slow_strobe && !done && !pend_q |=> !valid_out && $stable(vec_out)); // R6
  AST_IDLE_SLOT_QUIET: assert property (@(posedge clk) disable iff (rst)
    cnt >= CW'(RATIO) |=> $stable(idx) && $stable(open_q) && $stable(acc)); // R8
  AST_FRAME_INDEX_RANGE: assert property (@(posedge clk) disable iff (rst)
    open_q |-> idx < IW'(RATIO)); // R9
endmodule

// File: tb/serial_frame_gatherer_tb.sv
module serial_frame_gatherer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int R = 3;
  localparam int IDLE = 1;
  localparam int P = R + IDLE;
  localparam logic [R*W-1:0] INIT = 24'hA5A5A5;

  logic clk = 1'b0, rst = 1'b1;
  logic [W-1:0] din = '0;
  logic valid_in = 1'b0, start_in = 1'b0;
  logic [R*W-1:0] vec_out;
  logic valid_out, slow_strobe;

  int checks = 0, errors = 0;
  string cur_req = "R7";
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_frame_gatherer #(.WIDTH(W), .RATIO(R), .IDLE_CYCLES(IDLE), .INIT_VEC(INIT)) dut_i (
    .clk(clk), .rst(rst), .din(din), .valid_in(valid_in), .start_in(start_in),
    .vec_out(vec_out), .valid_out(valid_out), .slow_strobe(slow_strobe));

  int m_ph;
  bit m_open, m_pend, m_valid;
  logic [W-1:0] m_q[$];
  logic [R*W-1:0] m_out, m_pvec;

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_open = 0; m_pend = 0; m_valid = 0; m_out = INIT; m_q.delete();
    end else begin
      bit comp;
      logic [R*W-1:0] nv;
      comp = 0; nv = '0;
      if (m_ph < R && valid_in) begin
        if (start_in) begin m_q.delete(); m_q.push_back(din); m_open = 1; end
        else if (m_open) m_q.push_back(din);
        if (m_open && m_q.size() == R) begin
          for (int i = 0; i < R; i++) nv[i*W +: W] = m_q[i];
          comp = 1; m_open = 0; m_q.delete();
        end
      end
      if (m_ph == P - 1) begin
        if (comp) begin m_out = nv; m_valid = 1; end
        else if (m_pend) begin m_out = m_pvec; m_valid = 1; end
        else m_valid = 0;
        m_pend = 0;
      end else if (comp) begin m_pend = 1; m_pvec = nv; end
      m_ph = (m_ph + 1) % P;
    end
  end

  task automatic chk(string req, logic [R*W-1:0] act, logic [R*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!rst && !finished) begin
    chk("R1 strobe", R*W'(slow_strobe), R*W'(m_ph == P - 1));
    chk({cur_req, " vec"}, vec_out, m_out);
    chk({cur_req, " valid"}, R*W'(valid_out), R*W'(m_valid));
  end

  task automatic step(bit v, bit s, logic [W-1:0] d);
    valid_in = v; start_in = s; din = d;
    @(negedge clk);
  endtask

  task automatic to_phase(int k);
    while (m_ph != k) step(0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R7 reset vec", vec_out, INIT);
    chk("R7 reset valid", R*W'(valid_out), '0);
    rst = 1'b0;
    cur_req = "R6";
    repeat (2*P) step(0, 0, 0);
    chk("R7 held init", vec_out, INIT);

    cur_req = "R2";
    to_phase(0);
    step(1, 1, 8'h11); step(1, 0, 8'h22); step(1, 0, 8'h33); step(0, 0, 0);
    chk("R2 order", vec_out, {8'h33, 8'h22, 8'h11});
    chk("R3 valid after strobe", R*W'(valid_out), R*W'(1));

    cur_req = "R6";
    repeat (P) step(0, 0, 0);
    chk("R6 held vec", vec_out, {8'h33, 8'h22, 8'h11});
    chk("R6 valid low", R*W'(valid_out), '0);

    cur_req = "R8";
    to_phase(1);
    step(1, 1, 8'h41); step(1, 0, 8'h42); step(1, 1, 8'h99); step(1, 0, 8'h43);
    repeat (2*P) step(0, 0, 0);
    chk("R8 idle skipped", vec_out, {8'h43, 8'h42, 8'h41});

    cur_req = "R5";
    to_phase(0);
    step(1, 1, 8'h51); step(1, 1, 8'h52); step(1, 0, 8'h53); step(0, 0, 0);
    step(1, 0, 8'h54);
    repeat (2*P) step(0, 0, 0);
    chk("R5 restart", vec_out, {8'h54, 8'h53, 8'h52});

    cur_req = "R4";
    to_phase(0);
    step(0, 1, 8'h61); step(1, 0, 8'h62); step(1, 0, 8'h63);
    repeat (2*P) step(0, 0, 0);
    chk("R4 dropped", vec_out, {8'h54, 8'h53, 8'h52});

    cur_req = "R9";
    to_phase(0);
    step(1, 1, 8'h71); step(1, 0, 8'h72); step(1, 0, 8'h73); step(0, 0, 0);
    step(1, 0, 8'h74); step(1, 0, 8'h75); step(1, 0, 8'h76);
    repeat (2*P) step(0, 0, 0);
    chk("R9 closed", vec_out, {8'h73, 8'h72, 8'h71});
    chk("R9 no new valid", R*W'(valid_out), '0);

    cur_req = "R3";
    for (int n = 0; n < 3000; n++)
      step(($urandom % 4) != 0, ($urandom % 5) == 0, W'($urandom));

    cur_req = "R7";
    rst = 1'b1; step(0, 0, 0); rst = 1'b0;
    chk("R7 re-reset", vec_out, INIT);
    repeat (P) step(1, 0, 8'h80);
    chk("R7 no frame open", R*W'(valid_out), '0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule